// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block is a real-time clock. It keeps seconds, minutes, hours, day of month, month, a two-digit year and a weekday, each as a packed BCD value. A strobe input pulses once per period of a 32768 Hz reference, synchronous to the system clock. While the core runs, a prescaler counts these strobes. Each time the prescaler completes a second, the whole BCD carry chain advances in one clock cycle. The carry chain handles the length of each month and leap years, and the weekday steps on every day rollover.

Software reaches the core through a byte-wide register port. Reads are combinational; writes are single-cycle strobes. A control register starts and stops counting. A status register has three parts:
- a running flag;
- a busy flag, which warns that the counters are about to change during the current reference period;
- four sticky event flags for second, minute, hour and day rollovers, each cleared by writing 1 to it.

Software should wait for busy to be low before it reads or loads the time. It can then access all fields before the next increment. The year field holds the last two digits of a year from 2000 to 2099.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, the registers read as follows: seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00, weekday 0x06 (the weekday of 2000-01-01). Control and status both read 0x00.
- R2: While running, the seconds field advances by one BCD step after every TICKS_PER_SEC reference strobes. Seconds go from 0x59 to 0x00 and carry into minutes. Minutes go from 0x59 to 0x00 and carry into hours. Hours go from 0x23 to 0x00 and carry into the day.
- R3: Bit 0 of the control register (offset 0x40) is the run bit. While it is 0, the time fields and the prescaler hold their values. Status (offset 0x44) bit 1 reads back the run bit.
- R4: Status bit 0 (busy) is high for exactly the one reference period that ends in a seconds increment, and only while the core runs.
- R5: The day returns to 0x01 and carries into the month when it reaches a limit that depends on the month:
  - 0x31 for months 01, 03, 05, 07, 08, 10 and 12;
  - 0x30 for months 04, 06, 09 and 11;
  - 0x29 for month 02 in a leap year (a year value divisible by 4);
  - 0x28 for month 02 in any other year.
- R6: The weekday (offset 0x18) increments on every day rollover and goes from 0x06 to 0x00.
- R7: The month goes from 0x12 to 0x01 and carries into the year. The year goes from 0x99 to 0x00.
- R8: Status bits 2, 3, 4 and 5 are the event flags for the second, minute, hour and day rollovers. Each one sets on its rollover and stays set until software writes 1 to that bit. Writing 0 to a bit leaves it unchanged.
- R9: A write to a time field loads the value directly, with no BCD correction. Each field keeps only its low bits and reads back zero-extended. The field widths are: seconds (0x00) 7, minutes (0x04) 7, hours (0x08) 6, day (0x0C) 6, month (0x10) 5, year (0x14) 8, weekday (0x18) 3.
- R10: Any offset that is not mapped reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | One-cycle strobe per 32768 Hz reference period |
| regAddr | input | ADDR_W | Byte offset used for both reads and writes |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data at regAddr |

## Verification
The bench builds the core with TICKS_PER_SEC set to 4, so that a simulated second lasts only four reference strobes. This lets the bench cover the busy window, the stop behaviour and every carry from seconds through to the year in a short run. The bench loads boundary dates directly and then steps a single second:
- the last second of a day;
- the ends of 30-day and 31-day months;
- the end of February in leap and non-leap years;
- the end of the year at year 99.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] OFF_SEC    = 8'h00;
  localparam logic [7:0] OFF_MIN    = 8'h04;
  localparam logic [7:0] OFF_HOUR   = 8'h08;
  localparam logic [7:0] OFF_DAY    = 8'h0C;
  localparam logic [7:0] OFF_MONTH  = 8'h10;
  localparam logic [7:0] OFF_YEAR   = 8'h14;
  localparam logic [7:0] OFF_WDAY   = 8'h18;
  localparam logic [7:0] OFF_CTRL   = 8'h40;
  localparam logic [7:0] OFF_STATUS = 8'h44;

  // control -> datapath strobes
  typedef struct packed {
    logic advance;
    logic busy;
  } rtcStrobe_t;

  // datapath -> control rollover events
  typedef struct packed {
    logic day;
    logic hour;
    logic min;
    logic sec;
  } rollEv_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcdInc = {v[7:4] + 4'd1, 4'd0};
    else                bcdInc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic isLeap(input logic [7:0] y);
    logic [7:0] bin;
    bin = {1'b0, y[7:4], 3'b000} + {3'b000, y[7:4], 1'b0} + {4'h0, y[3:0]};
    isLeap = (bin[1:0] == 2'b00);
  endfunction

  function automatic logic [5:0] lastDay(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                        lastDay = isLeap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11:   lastDay = 6'h30;
      default:                      lastDay = 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  rollEv_t           rollEv,
  output rtcStrobe_t        strobes,
  output logic [7:0]        ctrlByte,
  output logic [7:0]        statusByte
);
  localparam int PRESC_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(TICKS_PER_SEC - 1);

  logic [PRESC_W-1:0] prescCnt;
  logic               runReg;
  logic [3:0]         evReg;
  logic               ctrlWr, statusWr;
  logic [3:0]         evSet;
  logic               unusedWrBits;

  assign ctrlWr   = regWrEn && (regAddr == ADDR_W'(OFF_CTRL));
  assign statusWr = regWrEn && (regAddr == ADDR_W'(OFF_STATUS));
  assign unusedWrBits = ^{regWrData[7:6], regWrData[1]};

  assign strobes.busy    = runReg && (prescCnt == PRESC_LAST);
  assign strobes.advance = strobes.busy && refTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg <= 1'b0;
    end else if (ctrlWr) begin
      runReg <= regWrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
    end else if (runReg && refTick) begin
      prescCnt <= (prescCnt == PRESC_LAST) ? '0 : prescCnt + 1'b1;
    end
  end

  assign evSet = {rollEv.day, rollEv.hour, rollEv.min, rollEv.sec};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evReg <= '0;
    end else begin
      evReg <= (evReg & ~(statusWr ? regWrData[5:2] : 4'h0)) | evSet;
    end
  end

  assign ctrlByte   = {7'b0, runReg};
  assign statusByte = {2'b00, evReg, runReg, strobes.busy};

  AST_BUSY_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busy && refTick) |=> !strobes.busy); // R4
  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (evReg[0] && !statusWr) |=> evReg[0]); // R8
  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (!runReg && !ctrlWr) |=> !strobes.advance); // R3
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output rollEv_t           rollEv,
  output logic [6:0]        secReg,
  output logic [6:0]        minReg,
  output logic [5:0]        hourReg,
  output logic [5:0]        dayReg,
  output logic [4:0]        monReg,
  output logic [7:0]        yearReg,
  output logic [2:0]        wdayReg
);
  logic secWr, minWr, hourWr, dayWr, monWr, yearWr, wdayWr;
  logic secWrap, minWrap, hourWrap, dayWrap, monWrap;
  logic dayCarry, monCarry, yearCarry;
  logic unusedBusy;

  assign unusedBusy = strobes.busy;

  assign secWr  = regWrEn && (regAddr == ADDR_W'(OFF_SEC));
  assign minWr  = regWrEn && (regAddr == ADDR_W'(OFF_MIN));
  assign hourWr = regWrEn && (regAddr == ADDR_W'(OFF_HOUR));
  assign dayWr  = regWrEn && (regAddr == ADDR_W'(OFF_DAY));
  assign monWr  = regWrEn && (regAddr == ADDR_W'(OFF_MONTH));
  assign yearWr = regWrEn && (regAddr == ADDR_W'(OFF_YEAR));
  assign wdayWr = regWrEn && (regAddr == ADDR_W'(OFF_WDAY));

  assign secWrap  = secReg  >= 7'h59;
  assign minWrap  = minReg  >= 7'h59;
  assign hourWrap = hourReg >= 6'h23;
  assign dayWrap  = dayReg  >= lastDay(monReg, yearReg);
  assign monWrap  = monReg  >= 5'h12;

  // carry chain, all stages resolved in the same cycle
  assign rollEv.sec  = strobes.advance;
  assign rollEv.min  = rollEv.sec  && secWrap;
  assign rollEv.hour = rollEv.min  && minWrap;
  assign rollEv.day  = rollEv.hour && hourWrap;
  assign dayCarry    = rollEv.day;
  assign monCarry    = dayCarry && dayWrap;
  assign yearCarry   = monCarry && monWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secReg  <= 7'h00;
      minReg  <= 7'h00;
      hourReg <= 6'h00;
      dayReg  <= 6'h01;
      monReg  <= 5'h01;
      yearReg <= 8'h00;
      wdayReg <= 3'd6;
    end else begin
      if (secWr)             secReg <= regWrData[6:0];
      else if (rollEv.sec)   secReg <= secWrap ? 7'h00 : bcdInc({1'b0, secReg})[6:0];

      if (minWr)             minReg <= regWrData[6:0];
      else if (rollEv.min)   minReg <= minWrap ? 7'h00 : bcdInc({1'b0, minReg})[6:0];

      if (hourWr)            hourReg <= regWrData[5:0];
      else if (rollEv.hour)  hourReg <= hourWrap ? 6'h00 : bcdInc({2'b0, hourReg})[5:0];

      if (dayWr)             dayReg <= regWrData[5:0];
      else if (dayCarry)     dayReg <= dayWrap ? 6'h01 : bcdInc({2'b0, dayReg})[5:0];

      if (wdayWr)            wdayReg <= regWrData[2:0];
      else if (dayCarry)     wdayReg <= (wdayReg >= 3'd6) ? 3'd0 : wdayReg + 3'd1;

      if (monWr)             monReg <= regWrData[4:0];
      else if (monCarry)     monReg <= monWrap ? 5'h01 : bcdInc({3'b0, monReg})[4:0];

      if (yearWr)            yearReg <= regWrData;
      else if (yearCarry)    yearReg <= (yearReg >= 8'h99) ? 8'h00 : bcdInc(yearReg);
    end
  end

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && secReg == 7'h59 && !secWr) |=> secReg == 7'h00); // R2
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !secWr) |=> $stable(secReg)); // R3
  AST_MONTH_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (monCarry && monReg == 5'h12 && !monWr) |=> monReg == 5'h01); // R7
  AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (dayCarry && wdayReg == 3'd6 && !wdayWr) |=> wdayReg == 3'd0); // R6
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData
);
  rtcStrobe_t strobes;
  rollEv_t    rollEv;
  logic [7:0] ctrlByte, statusByte;
  logic [6:0] secReg, minReg;
  logic [5:0] hourReg, dayReg;
  logic [4:0] monReg;
  logic [7:0] yearReg;
  logic [2:0] wdayReg;

  rtc_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .refTick(refTick),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .rollEv(rollEv), .strobes(strobes),
    .ctrlByte(ctrlByte), .statusByte(statusByte)
  );

  rtc_datapath #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .rollEv(rollEv),
    .secReg(secReg), .minReg(minReg), .hourReg(hourReg), .dayReg(dayReg),
    .monReg(monReg), .yearReg(yearReg), .wdayReg(wdayReg)
  );

  always_comb begin
    regRdData = 8'h00;
    case (regAddr)
      ADDR_W'(OFF_SEC):    regRdData = {1'b0, secReg};
      ADDR_W'(OFF_MIN):    regRdData = {1'b0, minReg};
      ADDR_W'(OFF_HOUR):   regRdData = {2'b0, hourReg};
      ADDR_W'(OFF_DAY):    regRdData = {2'b0, dayReg};
      ADDR_W'(OFF_MONTH):  regRdData = {3'b0, monReg};
      ADDR_W'(OFF_YEAR):   regRdData = yearReg;
      ADDR_W'(OFF_WDAY):   regRdData = {5'b0, wdayReg};
      ADDR_W'(OFF_CTRL):   regRdData = ctrlByte;
      ADDR_W'(OFF_STATUS): regRdData = statusByte;
      default:             regRdData = 8'h00;
    endcase
  end
endmodule

// File: tb/rtc_bcd_core_tb.sv
`timescale 1ns/1ps
module rtc_bcd_core_tb;
  localparam int TPS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] addr;
    logic [7:0] exp;
    string      tag;
  } expItem_t;
  expItem_t sbQueue[$];
  event sampleEv;

  rtc_bcd_core #(.TICKS_PER_SEC(TPS), .ADDR_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .refTick(refTick),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  always #2 clk = ~clk;

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      finishRun();
    end
  end

  // monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      @(sampleEv);
      #1;
      begin
        expItem_t it;
        it = sbQueue.pop_front();
        checks++;
        if (regRdData !== it.exp) begin
          errors++;
          $display("FAIL %s addr=%02h actual=%02h expected=%02h",
                   it.tag, it.addr, regRdData, it.exp);
        end
      end
    end
  end

  task automatic expectRead(input logic [7:0] a, input logic [7:0] e, input string tag);
    expItem_t it;
    @(negedge clk);
    regAddr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sbQueue.push_back(it);
    -> sampleEv;
    #1.5;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); refTick = 1'b1;
      @(negedge clk); refTick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic setTime(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                         input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y,
                         input logic [7:0] wd);
    wr(8'h00, s); wr(8'h04, mi); wr(8'h08, h); wr(8'h0C, d);
    wr(8'h10, mo); wr(8'h14, y); wr(8'h18, wd);
    wr(8'h44, 8'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R10 unmapped
    expectRead(8'h00, 8'h00, "R1 sec");
    expectRead(8'h04, 8'h00, "R1 min");
    expectRead(8'h08, 8'h00, "R1 hour");
    expectRead(8'h0C, 8'h01, "R1 day");
    expectRead(8'h10, 8'h01, "R1 month");
    expectRead(8'h14, 8'h00, "R1 year");
    expectRead(8'h18, 8'h06, "R1 wday");
    expectRead(8'h40, 8'h00, "R1 ctrl");
    expectRead(8'h44, 8'h00, "R1 status");
    expectRead(8'h1C, 8'h00, "R10 unmapped 1C");
    expectRead(8'h48, 8'h00, "R10 unmapped 48");

    // R3 run, R4 busy window, R2 advance, R8 events
    wr(8'h40, 8'h01);
    expectRead(8'h44, 8'h02, "R3 running flag");
    ticks(TPS - 2);
    expectRead(8'h44, 8'h02, "R4 not busy early");
    ticks(1);
    expectRead(8'h44, 8'h03, "R4 busy before increment");
    expectRead(8'h00, 8'h00, "R2 sec not yet advanced");
    ticks(1);
    expectRead(8'h00, 8'h01, "R2 sec advanced");
    expectRead(8'h44, 8'h06, "R8 sec event set, R4 busy dropped");
    wr(8'h44, 8'h04);
    expectRead(8'h44, 8'h02, "R8 sec event cleared");
    ticks(TPS);
    wr(8'h44, 8'h00);
    expectRead(8'h44, 8'h06, "R8 write 0 keeps event");
    expectRead(8'h00, 8'h02, "R2 second step");

    // R3 stop freezes
    wr(8'h40, 8'h00);
    ticks(2 * TPS);
    expectRead(8'h00, 8'h02, "R3 frozen sec");
    expectRead(8'h44, 8'h04, "R3 stopped status, R4 no busy");
    wr(8'h40, 8'h01);

    // minute carry only
    setTime(8'h59, 8'h12, 8'h05, 8'h10, 8'h06, 8'h30, 8'h02);
    ticks(TPS);
    expectRead(8'h00, 8'h00, "R2 sec wrap");
    expectRead(8'h04, 8'h13, "R2 min carry");
    expectRead(8'h08, 8'h05, "R2 hour unchanged");
    expectRead(8'h44, 8'h0E, "R8 sec+min events");

    // R5 Feb non-leap, R6 wday, R2 full day carry
    setTime(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h06);
    ticks(TPS);
    expectRead(8'h08, 8'h00, "R2 hour wrap");
    expectRead(8'h0C, 8'h01, "R5 feb 28 nonleap wrap");
    expectRead(8'h10, 8'h03, "R5 month carry");
    expectRead(8'h18, 8'h00, "R6 wday 6->0");
    expectRead(8'h44, 8'h3E, "R8 all events");

    // R5 leap year
    setTime(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h03);
    ticks(TPS);
    expectRead(8'h0C, 8'h29, "R5 leap feb 29");
    expectRead(8'h10, 8'h02, "R5 leap month held");
    expectRead(8'h18, 8'h04, "R6 wday inc");
    setTime(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24, 8'h04);
    ticks(TPS);
    expectRead(8'h0C, 8'h01, "R5 leap feb 29 wrap");
    expectRead(8'h10, 8'h03, "R5 leap march");

    // R5 30- and 31-day months
    setTime(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h24, 8'h01);
    ticks(TPS);
    expectRead(8'h0C, 8'h01, "R5 april 30 wrap");
    expectRead(8'h10, 8'h05, "R5 may");
    setTime(8'h59, 8'h59, 8'h23, 8'h30, 8'h08, 8'h24, 8'h01);
    ticks(TPS);
    expectRead(8'h0C, 8'h31, "R5 august 31 exists");
    expectRead(8'h10, 8'h08, "R5 august held");

    // R7 year end
    setTime(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h05);
    ticks(TPS);
    expectRead(8'h0C, 8'h01, "R7 day 01");
    expectRead(8'h10, 8'h01, "R7 month wrap");
    expectRead(8'h14, 8'h00, "R7 year wrap");
    expectRead(8'h18, 8'h06, "R6 wday 5->6");
    setTime(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h19, 8'h05);
    ticks(TPS);
    expectRead(8'h14, 8'h20, "R7 year bcd carry");

    // R9 raw loads with field masks
    wr(8'h40, 8'h00);
    wr(8'h00, 8'hFF);
    expectRead(8'h00, 8'h7F, "R9 sec mask");
    wr(8'h08, 8'hFF);
    expectRead(8'h08, 8'h3F, "R9 hour mask");
    wr(8'h10, 8'hFF);
    expectRead(8'h10, 8'h1F, "R9 month mask");
    wr(8'h18, 8'hFF);
    expectRead(8'h18, 8'h07, "R9 wday mask");
    wr(8'h14, 8'hAB);
    expectRead(8'h14, 8'hAB, "R9 year no correction");

    repeat (4) @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule